// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block picks the source of the system clock and keeps track of which operating mode the clock generator is in. Software programs three small control registers over a byte-wide write/read port. From these registers the block chooses among the locked-loop output, an internal reference and an external reference. It also chooses which reference feeds the loop, the loop's reference divider, and FLL or PLL operation. A fourth register reports status.

Status does not report the requested settings. It reports what the hardware is actually doing. A source, reference or loop change shows up in status only after the switchover has finished, so software polls status to follow a mode sequence.

The clock inputs are modelled as single-cycle tick enables sampled on the block clock `clk`. The output `out_tick` is the gated tick of whichever source is active. The analog loop is replaced by a behavioural model with three parts:
- an enable;
- a divided-reference lock counter;
- a pass-through of the selected reference tick.

A low-power bit stops the loop in the bypass modes. While the loop is stopped, loop-select and divider writes are kept for later use.

Top module: `cgm_mode_ctrl`

## Requirements
- R1: Register map, selected by `addr`:
  - Address 0 is control 1. All eight bits are stored. Bits 7:6 are the source request (00 loop, 01 internal, 10 external), bits 5:3 are the divider exponent, and bit 2 is the loop reference (1 internal, 0 external).
  - Address 1 is control 2. Only bit 3, low power, is stored; the other bits read 0.
  - Address 2 is control 3. Only bit 6, the loop select (1 PLL, 0 FLL), is stored; the other bits read 0.
  - Address 3 is status and is read-only. A write to it has no effect.
- R2: After reset, control 1 reads 0x04, control 2 and control 3 read 0x00, status reads 0x10, `mode_o` is 0, `src_sel` is 00 and `lock_o` is 0.
- R3: Status bits 3:2 (and `src_sel`) take a newly requested source only after two ticks of that source. They still show the old source one cycle after the write.
- R4: `out_tick` pulses only when the source shown in status bits 3:2 ticks. It stays low while a switchover is in progress. Once settled, it repeats every tick of that source.
- R5: Status bit 4 takes the requested loop reference only after two ticks of the new reference. One cycle after the write it still shows the old value.
- R6: The lock counter counts reference ticks divided by 2 to the power of control 1 bits 5:3. A larger divider therefore delays lock proportionally.
- R7: Status bit 5 follows the loop select only after two ticks of the running loop.
- R8: Status bit 6 (and `lock_o`) rises after LOCK_CYCLES divided reference ticks with an unchanged, enabled configuration. It drops in the cycle after a write that changes the loop select, the divider or the loop reference, or that disables the loop.
- R9: With low power set and a source other than the loop requested, the loop is off: lock stays 0 and status bit 5 is frozen while loop-select writes are held. Clearing low power lets the held setting settle and lock reacquire.
- R10: `mode_o` decodes the control bits:
  - 0: loop source, FLL, internal reference;
  - 1: loop source, FLL, external reference;
  - 2: internal source, low power off;
  - 3: external source, FLL, low power off;
  - 4: loop source, PLL;
  - 5: external source, PLL, low power off;
  - 6: internal source, low power on;
  - 7: external source, low power on.
- R11: A control 1 write with 11 in bits 7:6 is dropped entirely.
- R12: The sequence 0x90 to control 1, 0xB8 to control 1, 0x04 to control 3 and 0x44 to control 1 ends with these settled values in turn:
  - external source with external reference (status 3:2 = 10, bit 4 = 0);
  - divider 111;
  - FLL (bit 5 = 0);
  - internal source with internal reference (status 3:2 = 01, bit 4 = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irc_tick | input | 1 | Internal reference tick |
| erc_tick | input | 1 | External reference tick |
| out_tick | output | 1 | Gated tick of the active source |
| src_sel | output | 2 | Active source (same as status 3:2) |
| mode_o | output | 3 | Decoded mode, encoding per R10 |
| lock_o | output | 1 | Loop lock flag |

## Verification
The bench goes after the moment just after a write, when status must still show the old source or reference. A design that reports the request at once would let software skip the wait for a clock that is not yet running. It also checks that `out_tick` only ever carries pulses of the reported source. A mux that swaps without a pause would emit a pulse of the wrong source during the switch. The lock flag is checked for dropping on a divider or loop-select change and for taking longer with a larger divider. Low power is checked for holding the loop-select status frozen; a design that did not really stop the loop would let status bit 5 move.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
    localparam int RDIV_W    = 3;
    localparam int DIV_CNT_W = (1 << RDIV_W) - 1;

    localparam logic [1:0] SRC_LOOP = 2'b00;
    localparam logic [1:0] SRC_INT  = 2'b01;
    localparam logic [1:0] SRC_EXT  = 2'b10;
    localparam logic [1:0] SRC_BAD  = 2'b11;

    localparam logic [1:0] A_CTL1 = 2'd0;
    localparam logic [1:0] A_CTL2 = 2'd1;
    localparam logic [1:0] A_CTL3 = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic [1:0]        src;
        logic [RDIV_W-1:0] rdiv;
        logic              iref;
        logic [1:0]        spare;
    } ctl1_t;

    typedef enum logic [2:0] {
        MODE_LOOP_IREF = 3'd0,
        MODE_LOOP_EREF = 3'd1,
        MODE_BYP_IREF  = 3'd2,
        MODE_BYP_EREF  = 3'd3,
        MODE_PLL_ENG   = 3'd4,
        MODE_PLL_BYP   = 3'd5,
        MODE_LP_IREF   = 3'd6,
        MODE_LP_EREF   = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SW_STEADY = 2'd0,
        SW_SYNC_A = 2'd1,
        SW_SYNC_B = 2'd2
    } sw_state_e;
endpackage

// File: rtl/cgm_bit_settle.sv
// Reported bit follows its target after two ticks of the destination clock.
module cgm_bit_settle #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic target,
    input  logic dst_tick,
    output logic cur
);
    logic half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= RESET_VAL;
            half <= 1'b0;
        end else if (target == cur) begin
            half <= 1'b0;
        end else if (dst_tick) begin
            if (half) begin
                cur  <= target;
                half <= 1'b0;
            end else begin
                half <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cgm_loop_model.sv
// Behavioural loop: enable, divided-reference lock counter, pass-through tick.
module cgm_loop_model
    import cgm_pkg::*;
#(
    parameter int LOCK_CYCLES = 8,
    parameter int CFG_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [RDIV_W-1:0] rdiv,
    input  logic              ref_tick,
    output logic              loop_tick,
    output logic              lock
);
    localparam int LCK_W = $clog2(LOCK_CYCLES + 1);

    logic [CFG_W-1:0]     cfg_q;
    logic [DIV_CNT_W-1:0] div_cnt;
    logic [DIV_CNT_W-1:0] div_mask;
    logic [LCK_W-1:0]     lock_cnt;
    logic                 lock_q;
    logic                 cfg_same;
    logic                 div_done;

    assign cfg_same  = (cfg == cfg_q);
    assign div_mask  = DIV_CNT_W'((32'd1 << rdiv) - 32'd1);
    assign div_done  = ((div_cnt & div_mask) == div_mask);
    assign loop_tick = ref_tick & en;
    assign lock      = lock_q & en & cfg_same;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            div_cnt  <= '0;
            lock_cnt <= '0;
            lock_q   <= 1'b0;
        end else begin
            cfg_q <= cfg;
            if (!en || !cfg_same) begin
                div_cnt  <= '0;
                lock_cnt <= '0;
                lock_q   <= 1'b0;
            end else if (ref_tick) begin
                if (div_done) begin
                    div_cnt <= '0;
                    if (lock_cnt == LCK_W'(LOCK_CYCLES - 1)) begin
                        lock_q <= 1'b1;
                    end else begin
                        lock_cnt <= lock_cnt + 1'b1;
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cgm_src_switch.sv
// Glitch-free source switch: halt output, wait two destination ticks, commit.
module cgm_src_switch
    import cgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       tick_loop,
    input  logic       tick_int,
    input  logic       tick_ext,
    output logic [1:0] active,
    output logic       out_tick,
    output logic       busy
);
    sw_state_e  st_q, st_n;
    logic [1:0] tgt_q, tgt_n, act_n;
    logic       dst_tick, act_tick;

    function automatic logic sel_tick(input logic [1:0] s, input logic tl,
                                      input logic ti, input logic te);
        unique case (s)
            SRC_LOOP: sel_tick = tl;
            SRC_INT:  sel_tick = ti;
            SRC_EXT:  sel_tick = te;
            default:  sel_tick = 1'b0;
        endcase
    endfunction

    assign dst_tick = sel_tick(tgt_q, tick_loop, tick_int, tick_ext);
    assign act_tick = sel_tick(active, tick_loop, tick_int, tick_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SW_STEADY;
            tgt_q  <= SRC_LOOP;
            active <= SRC_LOOP;
        end else begin
            st_q   <= st_n;
            tgt_q  <= tgt_n;
            active <= act_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        tgt_n = tgt_q;
        act_n = active;
        unique case (st_q)
            SW_STEADY: begin
                if (req != active) begin
                    tgt_n = req;
                    st_n  = SW_SYNC_A;
                end
            end
            SW_SYNC_A, SW_SYNC_B: begin
                if (req != tgt_q) begin
                    tgt_n = req;
                    st_n  = (req == active) ? SW_STEADY : SW_SYNC_A;
                end else if (dst_tick) begin
                    if (st_q == SW_SYNC_A) begin
                        st_n = SW_SYNC_B;
                    end else begin
                        act_n = tgt_q;
                        st_n  = SW_STEADY;
                    end
                end
            end
            default: st_n = SW_STEADY;
        endcase
    end

    always_comb begin
        busy     = (st_q != SW_STEADY);
        out_tick = !busy && act_tick;
    end
endmodule

// File: rtl/cgm_mode_ctrl.sv
module cgm_mode_ctrl
    import cgm_pkg::*;
#(
    parameter int LOCK_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       irc_tick,
    input  logic       erc_tick,
    output logic       out_tick,
    output logic [1:0] src_sel,
    output logic [2:0] mode_o,
    output logic       lock_o
);
    localparam int CFG_W = RDIV_W + 2;

    ctl1_t      ctl1_q;
    logic       lp_q, pll_q;
    logic       loop_en, iref_st, pll_st;
    logic       iref_dst, loop_ref_tick, loop_tick;
    logic       sw_busy;
    logic [1:0] sw_active;
    logic [7:0] status;
    mode_e      mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1_q <= ctl1_t'(8'h04);
            lp_q   <= 1'b0;
            pll_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTL1: if (wdata[7:6] != SRC_BAD) ctl1_q <= ctl1_t'(wdata);
                A_CTL2: lp_q  <= wdata[3];
                A_CTL3: pll_q <= wdata[6];
                default: ;
            endcase
        end
    end

    assign loop_en       = (ctl1_q.src == SRC_LOOP) || !lp_q;
    assign iref_dst      = ctl1_q.iref ? irc_tick : erc_tick;
    assign loop_ref_tick = iref_st ? irc_tick : erc_tick;

    cgm_bit_settle #(.RESET_VAL(1'b1)) u_iref_settle (
        .clk(clk), .rst_n(rst_n), .target(ctl1_q.iref),
        .dst_tick(iref_dst), .cur(iref_st)
    );

    cgm_loop_model #(.LOCK_CYCLES(LOCK_CYCLES), .CFG_W(CFG_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .en(loop_en),
        .cfg({pll_q, ctl1_q.rdiv, ctl1_q.iref}), .rdiv(ctl1_q.rdiv),
        .ref_tick(loop_ref_tick), .loop_tick(loop_tick), .lock(lock_o)
    );

    cgm_bit_settle #(.RESET_VAL(1'b0)) u_pll_settle (
        .clk(clk), .rst_n(rst_n), .target(pll_q),
        .dst_tick(loop_tick), .cur(pll_st)
    );

    cgm_src_switch u_switch (
        .clk(clk), .rst_n(rst_n), .req(ctl1_q.src),
        .tick_loop(loop_tick), .tick_int(irc_tick), .tick_ext(erc_tick),
        .active(sw_active), .out_tick(out_tick), .busy(sw_busy)
    );

    assign src_sel = sw_active;
    assign status  = {1'b0, lock_o, pll_st, iref_st, sw_active, 2'b00};

    always_comb begin
        unique case (ctl1_q.src)
            SRC_LOOP: mode = pll_q ? MODE_PLL_ENG
                           : (ctl1_q.iref ? MODE_LOOP_IREF : MODE_LOOP_EREF);
            SRC_INT:  mode = lp_q ? MODE_LP_IREF : MODE_BYP_IREF;
            SRC_EXT:  mode = lp_q ? MODE_LP_EREF
                           : (pll_q ? MODE_PLL_BYP : MODE_BYP_EREF);
            default:  mode = MODE_BYP_EREF;
        endcase
    end
    assign mode_o = mode;

    always_comb begin
        unique case (addr)
            A_CTL1:  rdata = ctl1_q;
            A_CTL2:  rdata = {4'b0, lp_q, 3'b0};
            A_CTL3:  rdata = {1'b0, pll_q, 6'b0};
            default: rdata = status;
        endcase
    end
endmodule

// File: rtl/cgm_mode_ctrl_chk.sv
module cgm_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] clkst,
    input logic       out_tick,
    input logic       tick_int,
    input logic       tick_ext,
    input logic       tick_loop,
    input logic       lock,
    input logic       loop_en,
    input logic       sw_busy
);
    logic src_tick;
    always_comb begin
        unique case (clkst)
            2'b00:   src_tick = tick_loop;
            2'b01:   src_tick = tick_int;
            2'b10:   src_tick = tick_ext;
            default: src_tick = 1'b0;
        endcase
    end

    AST_OUT_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> src_tick); // R4
    AST_QUIET_IN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy |-> !out_tick); // R4
    AST_SRC_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (clkst != $past(clkst)) |-> $past(sw_busy)); // R3
    AST_LOCK_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> !lock); // R9
    AST_LOCK_RISE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(loop_en)); // R8
    AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        clkst != 2'b11); // R11
endmodule

bind cgm_mode_ctrl cgm_mode_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .clkst(sw_active), .out_tick(out_tick),
    .tick_int(irc_tick), .tick_ext(erc_tick), .tick_loop(loop_tick),
    .lock(lock_o), .loop_en(loop_en), .sw_busy(sw_busy)
);

// File: tb/cgm_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module cgm_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irc_tick = 1'b0, erc_tick = 1'b0;
    logic       out_tick, lock_o;
    logic [1:0] src_sel;
    logic [2:0] mode_o;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    cgm_mode_ctrl #(.LOCK_CYCLES(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irc_tick(irc_tick), .erc_tick(erc_tick),
        .out_tick(out_tick), .src_sel(src_sel), .mode_o(mode_o), .lock_o(lock_o)
    );

    // reference ticks: internal every 3 cycles, external every 2
    initial begin
        int c3 = 0, c2 = 0;
        forever begin
            @(posedge clk); #2;
            c3 = (c3 + 1) % 3; c2 = (c2 + 1) % 2;
            irc_tick = (c3 == 0); erc_tick = (c2 == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic wait_stat(input logic [7:0] m, input logic [7:0] w, input int maxc);
        logic [7:0] s;
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk); rd(2'd3, s);
            if ((s & m) == w) break;
        end
    endtask

    function automatic logic [2:0] exp_mode(input logic [1:0] s, input logic ir,
                                            input logic lp, input logic pl);
        case (s)
            2'b00:   exp_mode = pl ? 3'd4 : (ir ? 3'd0 : 3'd1);
            2'b01:   exp_mode = lp ? 3'd6 : 3'd2;
            default: exp_mode = lp ? 3'd7 : (pl ? 3'd5 : 3'd3);
        endcase
    endfunction

    function automatic logic src_tick(input logic [1:0] s, input logic ir,
                                      input logic ti, input logic te);
        case (s)
            2'b00:   src_tick = ir ? ti : te;
            2'b01:   src_tick = ti;
            default: src_tick = te;
        endcase
    endfunction

    task automatic chk_out(input string req, input logic [1:0] s, input logic ir);
        int miss = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); #1;
            if (out_tick !== src_tick(s, ir, irc_tick, erc_tick)) miss++;
        end
        chk(req, miss, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, s0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        rd(2'd0, d); chk("R2 ctl1", d, 8'h04);
        rd(2'd1, d); chk("R2 ctl2", d, 8'h00);
        rd(2'd2, d); chk("R2 ctl3", d, 8'h00);
        rd(2'd3, d); chk("R2 status", d, 8'h10);
        chk("R2 mode", mode_o, 0); chk("R2 src", src_sel, 0); chk("R2 lock", lock_o, 0);
        // R1 status is read-only, reserved bits read zero
        rd(2'd3, s0); wr(2'd3, 8'hFF); rd(2'd3, d); chk("R1 status write", d, s0);
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R1 ctl2", d, 8'h08);
        wr(2'd2, 8'hFF); rd(2'd2, d); chk("R1 ctl3", d, 8'h40);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wait_stat(8'h3C, 8'h10, 60);
        // R12 example sequence, with R3/R5 early checks
        wr(2'd0, 8'h90);
        rd(2'd3, d); chk("R3 src not early", d[3:2], 2'b00);
        wait_stat(8'h3C, 8'h08, 60); rd(2'd3, d);
        chk("R12 0x90 status", d[4:2], 3'b010); chk("R12 0x90 mode", mode_o, 3);
        wr(2'd0, 8'hB8); wait_stat(8'h3C, 8'h08, 60);
        rd(2'd0, d); chk("R12 0xB8 ctl1", d, 8'hB8);
        rd(2'd3, d); chk("R12 0xB8 status", d[4:2], 3'b010);
        wr(2'd2, 8'h04); rd(2'd2, d); chk("R12 ctl3 FLL", d, 8'h00);
        wait_stat(8'h20, 8'h00, 60); rd(2'd3, d); chk("R12 FLL status", d[5], 0);
        wr(2'd0, 8'h44);
        rd(2'd3, d); chk("R5 iref not early", d[4], 0); chk("R3 src held", d[3:2], 2'b10);
        wait_stat(8'h1C, 8'h14, 60); rd(2'd3, d);
        chk("R12 0x44 status", d[4:2], 3'b101); chk("R12 0x44 mode", mode_o, 2);
        // R8 / R6 lock timing
        wr(2'd0, 8'h00); chk("R10 loop ext mode", mode_o, 1);
        repeat (10) @(negedge clk); chk("R8 lock not early", lock_o, 0);
        wait_stat(8'h40, 8'h40, 200); chk("R8 lock acquired", lock_o, 1);
        wr(2'd0, 8'h10); #1; chk("R8 lock drops on divider", lock_o, 0);
        repeat (40) @(negedge clk); chk("R6 divider slows lock", lock_o, 0);
        wait_stat(8'h40, 8'h40, 400); chk("R6 lock with divider", lock_o, 1);
        wr(2'd2, 8'h40); #1; chk("R8 lock drops on loop select", lock_o, 0);
        chk("R10 pll mode", mode_o, 4);
        wait_stat(8'h20, 8'h20, 60); rd(2'd3, d); chk("R7 pll status", d[5], 1);
        // R9 low power
        wr(2'd0, 8'h80); chk("R10 pll bypass mode", mode_o, 5);
        wait_stat(8'h4C, 8'h48, 200); chk("R9 lock in bypass", lock_o, 1);
        wr(2'd1, 8'h08); #1; chk("R9 lock off in low power", lock_o, 0);
        chk("R10 lp ext mode", mode_o, 7);
        wr(2'd2, 8'h00); repeat (20) @(negedge clk);
        rd(2'd3, d); chk("R9 pll status frozen", d[5], 1); chk("R9 lock stays off", d[6], 0);
        wr(2'd1, 8'h00); wait_stat(8'h60, 8'h40, 200);
        rd(2'd3, d); chk("R9 resume pll status", d[5], 0); chk("R9 relock", d[6], 1);
        // R11 reserved source request
        rd(2'd0, s0); wr(2'd0, 8'hC4); rd(2'd0, d); chk("R11 write dropped", d, s0);
        repeat (20) @(negedge clk); chk("R11 src unchanged", src_sel, s0[7:6]);
        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [1:0] s; logic [2:0] rv; logic ir, lp, pl; logic [1:0] sp; logic [7:0] c1;
            s = 2'($urandom % 3); rv = 3'($urandom); ir = 1'($urandom);
            lp = 1'($urandom); pl = 1'($urandom); sp = 2'($urandom);
            c1 = {s, rv, ir, sp};
            wr(2'd1, 8'h00); wr(2'd2, {1'b0, pl, 6'b0}); wr(2'd0, c1);
            wait_stat(8'h3C, {2'b00, pl, ir, s, 2'b00}, 80);
            rd(2'd3, d); chk("R3 R5 R7 rand status", d[5:2], {pl, ir, s});
            rd(2'd0, d); chk("R1 rand ctl1", d, c1);
            chk("R3 rand src_sel", src_sel, s);
            chk("R10 rand mode", mode_o, exp_mode(s, ir, 1'b0, pl));
            chk_out("R4 rand out_tick", s, ir);
            if (lp) begin
                wr(2'd1, 8'h08);
                chk("R10 rand lp mode", mode_o, exp_mode(s, ir, 1'b1, pl));
                if (s != 2'b00) begin
                    wr(2'd2, {1'b0, ~pl, 6'b0}); repeat (20) @(negedge clk);
                    rd(2'd3, d);
                    chk("R9 rand frozen", d[5], pl); chk("R9 rand no lock", d[6], 0);
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule